// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Sync

This block turns one fast source clock into four bank clocks and one feedback clock. Each output divides the source by an even ratio picked from a fixed map. A bank-select code sets three of the banks at once. A separate feedback-select code sets the feedback output. An optional divide-by-two stage can sit ahead of all the dividers. Every output has a 50% duty cycle. All outputs restart together when the master reset is released, so after reset every output has a rising edge at the same instant.

The fourth bank has two uses. In sync mode it marks rising edges that bank A and bank C share, which shows the common phase when the two banks run at ratios that are not whole multiples of each other. In copy mode it repeats bank C. The select inputs are sampled only while the master reset is high. A running block therefore keeps its phase relationships until the next reset.

Everything runs on the source clock. The divide-by-two stage is a clock enable, not a separate derived clock.

Top module: `multibank_clkdiv`

## Requirements
- R1: While `masterRst` is high at a rising source edge, all five outputs are low after that edge.
- R2: Bank A divides by a ratio set by `bankSel`. Codes 0 through 9 give 2, codes 10 through 12 give 4, codes 13 and 14 give 6, and code 15 gives 8.
- R3: Bank B divides by a ratio set by `bankSel`. For codes 0 through 15 in rising order the ratios are 2,2,4,2,6,4,4,6,2,8,4,6,6,6,8,8.
- R4: Bank C divides by a ratio set by `bankSel`. Code 0 gives 2. Codes 1 and 2 give 4. Codes 3, 4, 5, 10 and 11 give 6. Codes 6 through 9 and 12 through 15 give 8.
- R5: The feedback output divides by a ratio set by `fbSel`. For codes 0 through 7 in rising order the ratios are 2,4,6,8,8,16,24,32.
- R6: Each divided output is high for the first half of every period and low for the second half. All outputs go high on the first divider step after reset is released.
- R7: When `halfRate` is 1, a divider step happens on the 1st, 3rd, 5th, ... source edge after release. When it is 0, a divider step happens on every source edge.
- R8: When `syncSel` is 0, bank D goes high on each step where banks A and C rise together. It stays high for one bank-C period, measured in steps, so D is high at step k when (k-1) mod lcm(ratioA, ratioC) is less than ratioC.
- R9: When `syncSel` is 1, bank D equals bank C.
- R10: `bankSel`, `fbSel`, `halfRate` and `syncSel` are captured only while `masterRst` is high. Changes made while the block runs do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock; every register runs on its rising edge |
| masterRst | input | 1 | Active-high synchronous master reset; also opens the select capture |
| halfRate | input | 1 | 1 = divide the source by two before the bank dividers |
| bankSel | input | 4 | Ratio code for banks A, B and C |
| fbSel | input | 3 | Ratio code for the feedback output |
| syncSel | input | 1 | 0 = bank D is the A/C coincidence pulse, 1 = bank D copies bank C |
| bankAOut | output | 1 | Bank A clock |
| bankBOut | output | 1 | Bank B clock |
| bankCOut | output | 1 | Bank C clock |
| bankDOut | output | 1 | Bank D clock or sync pulse |
| fbOut | output | 1 | Feedback clock |

## Verification
The bench uses the package defaults: a largest ratio of 32, which gives 6-bit ratios and 5-bit half-period counters. With these widths the divide-by-32 feedback code can be reached, and it is run with the half-rate stage on. That gives the longest period the counters must hold. The five A:C pairings 1:1, 2:1, 3:1, 3:2 and 4:3 are each run for more than one full common period, so the sync pulse is seen both re-firing and dropping. Two runs change every select input halfway through to show that the changes are ignored.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  localparam int MAX_RATIO  = 32;
  localparam int RATIO_W    = $clog2(MAX_RATIO) + 1;
  localparam int HALF_W     = RATIO_W - 1;
  localparam int BANK_SEL_W = 4;
  localparam int FB_SEL_W   = 3;
  localparam int NUM_DIV    = 4;

  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;
  localparam int IDX_C  = 2;
  localparam int IDX_FB = 3;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [HALF_W-1:0]  half_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;   // dividers held cleared
    logic tick;   // one divider step on this edge
  } ctrl_strobe_t;

  function automatic ratio_t ratioOfA(input logic [BANK_SEL_W-1:0] code);
    ratio_t r;
    if (code <= 4'd9)       r = ratio_t'(2);
    else if (code <= 4'd12) r = ratio_t'(4);
    else if (code <= 4'd14) r = ratio_t'(6);
    else                    r = ratio_t'(8);
    return r;
  endfunction

  function automatic ratio_t ratioOfB(input logic [BANK_SEL_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0, 4'd1, 4'd3, 4'd8:               r = ratio_t'(2);
      4'd2, 4'd5, 4'd6, 4'd10:              r = ratio_t'(4);
      4'd4, 4'd7, 4'd11, 4'd12, 4'd13:      r = ratio_t'(6);
      default:                              r = ratio_t'(8);
    endcase
    return r;
  endfunction

  function automatic ratio_t ratioOfC(input logic [BANK_SEL_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0:                                 r = ratio_t'(2);
      4'd1, 4'd2:                           r = ratio_t'(4);
      4'd3, 4'd4, 4'd5, 4'd10, 4'd11:       r = ratio_t'(6);
      default:                              r = ratio_t'(8);
    endcase
    return r;
  endfunction

  function automatic ratio_t ratioOfFb(input logic [FB_SEL_W-1:0] code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(2);
      3'd1:    r = ratio_t'(4);
      3'd2:    r = ratio_t'(6);
      3'd3,
      3'd4:    r = ratio_t'(8);
      3'd5:    r = ratio_t'(16);
      3'd6:    r = ratio_t'(24);
      default: r = ratio_t'(32);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbd_control.sv
module mbd_control
  import mbd_pkg::*;
(
  input  logic                  clk,
  input  logic                  masterRst,
  input  logic                  halfRate,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic [FB_SEL_W-1:0]   fbSel,
  input  logic                  syncSel,
  output ctrl_strobe_t          strobe,
  output half_t [NUM_DIV-1:0]   halfRatio,
  output ratio_t                syncSpan,
  output logic                  syncMode,
  output logic                  halfMode
);

  logic [BANK_SEL_W-1:0] bankSelQ;
  logic [FB_SEL_W-1:0]   fbSelQ;
  logic                  preTog;
  ratio_t                fullRatio [NUM_DIV];

  // selections are only open while the master reset is held
  always_ff @(posedge clk) begin
    if (masterRst) begin
      bankSelQ <= bankSel;
      fbSelQ   <= fbSel;
      halfMode <= halfRate;
      syncMode <= syncSel;
    end
  end

  // pre-divide phase: step on the first released edge, then every other one
  always_ff @(posedge clk) begin
    if (masterRst) preTog <= 1'b0;
    else           preTog <= ~preTog;
  end

  always_comb begin
    strobe.hold = masterRst;
    strobe.tick = !masterRst && (!halfMode || !preTog);
  end

  always_comb begin
    fullRatio[IDX_A]  = ratioOfA(bankSelQ);
    fullRatio[IDX_B]  = ratioOfB(bankSelQ);
    fullRatio[IDX_C]  = ratioOfC(bankSelQ);
    fullRatio[IDX_FB] = ratioOfFb(fbSelQ);
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_half
    assign halfRatio[g] = fullRatio[g][RATIO_W-1:1];
  end

  assign syncSpan = fullRatio[IDX_C];

endmodule

// File: rtl/mbd_divider.sv
module mbd_divider #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] halfRatio,
  output logic             clkOut,
  output logic             riseNow
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else if (tick) begin
      if (cnt == '0) clkOut <= ~clkOut;
      if (cnt == halfRatio - 1'b1) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end

  // this step turns the output from low to high
  assign riseNow = tick && !hold && (cnt == '0) && !clkOut;

endmodule

// File: rtl/mbd_datapath.sv
module mbd_datapath
  import mbd_pkg::*;
(
  input  logic                clk,
  input  ctrl_strobe_t        strobe,
  input  half_t [NUM_DIV-1:0] halfRatio,
  input  ratio_t              syncSpan,
  input  logic                syncMode,
  output logic [NUM_DIV-1:0]  divOut,
  output logic                bankD
);

  logic [NUM_DIV-1:0] riseVec;
  logic               syncQ;
  ratio_t             syncLeft;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    mbd_divider #(.CNT_W(HALF_W)) divider_i (
      .clk      (clk),
      .hold     (strobe.hold),
      .tick     (strobe.tick),
      .halfRatio(halfRatio[g]),
      .clkOut   (divOut[g]),
      .riseNow  (riseVec[g])
    );
  end

  // coincidence pulse: one bank-C period long, re-armed by each shared edge
  always_ff @(posedge clk) begin
    if (strobe.hold) begin
      syncQ    <= 1'b0;
      syncLeft <= '0;
    end else if (strobe.tick) begin
      if (riseVec[IDX_A] && riseVec[IDX_C]) begin
        syncQ    <= 1'b1;
        syncLeft <= syncSpan - 1'b1;
      end else if (syncLeft != '0) begin
        syncLeft <= syncLeft - 1'b1;
      end else begin
        syncQ <= 1'b0;
      end
    end
  end

  assign bankD = syncMode ? divOut[IDX_C] : syncQ;

endmodule

// File: rtl/multibank_clkdiv.sv
module multibank_clkdiv
  import mbd_pkg::*;
(
  input  logic       clk,
  input  logic       masterRst,
  input  logic       halfRate,
  input  logic [3:0] bankSel,
  input  logic [2:0] fbSel,
  input  logic       syncSel,
  output logic       bankAOut,
  output logic       bankBOut,
  output logic       bankCOut,
  output logic       bankDOut,
  output logic       fbOut
);

  ctrl_strobe_t        strobe;
  half_t [NUM_DIV-1:0] halfRatio;
  ratio_t              syncSpan;
  logic                syncMode;
  logic                halfMode;
  logic [NUM_DIV-1:0]  divOut;

  mbd_control control_i (
    .clk      (clk),
    .masterRst(masterRst),
    .halfRate (halfRate),
    .bankSel  (bankSel),
    .fbSel    (fbSel),
    .syncSel  (syncSel),
    .strobe   (strobe),
    .halfRatio(halfRatio),
    .syncSpan (syncSpan),
    .syncMode (syncMode),
    .halfMode (halfMode)
  );

  mbd_datapath datapath_i (
    .clk      (clk),
    .strobe   (strobe),
    .halfRatio(halfRatio),
    .syncSpan (syncSpan),
    .syncMode (syncMode),
    .divOut   (divOut),
    .bankD    (bankDOut)
  );

  assign bankAOut = divOut[IDX_A];
  assign bankBOut = divOut[IDX_B];
  assign bankCOut = divOut[IDX_C];
  assign fbOut    = divOut[IDX_FB];

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
  import mbd_pkg::*;
(
  input logic                clk,
  input logic                masterRst,
  input logic                bankAOut,
  input logic                bankBOut,
  input logic                bankCOut,
  input logic                bankDOut,
  input logic                fbOut,
  input logic                syncMode,
  input logic                halfMode,
  input half_t [NUM_DIV-1:0] halfRatio
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    masterRst |=> !bankAOut && !bankBOut && !bankCOut && !bankDOut && !fbOut);

  // R6
  common_first_rise_chk: assert property (@(posedge clk) disable iff (masterRst)
    $past(masterRst) && !masterRst |=> bankAOut && bankBOut && bankCOut && fbOut);

  // R7
  half_rate_spacing_chk: assert property (@(posedge clk) disable iff (masterRst)
    halfMode && (bankAOut != $past(bankAOut)) |=> $stable(bankAOut));

  // R8
  sync_on_shared_rise_chk: assert property (@(posedge clk) disable iff (masterRst)
    !syncMode && $rose(bankAOut) && $rose(bankCOut) |-> bankDOut);

  // R10
  selects_frozen_chk: assert property (@(posedge clk) disable iff (masterRst)
    !masterRst |=> $stable(halfRatio) && $stable(syncMode) && $stable(halfMode));

endmodule

bind multibank_clkdiv mbd_checker checker_i (
  .clk      (clk),
  .masterRst(masterRst),
  .bankAOut (bankAOut),
  .bankBOut (bankBOut),
  .bankCOut (bankCOut),
  .bankDOut (bankDOut),
  .fbOut    (fbOut),
  .syncMode (syncMode),
  .halfMode (halfMode),
  .halfRatio(halfRatio)
);

// File: tb/multibank_clkdiv_tb_top.sv
module multibank_clkdiv_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       masterRst = 1'b1;
  logic       halfRate = 1'b0;
  logic [3:0] bankSel = 4'd0;
  logic [2:0] fbSel = 3'd0;
  logic       syncSel = 1'b0;
  logic       bankAOut, bankBOut, bankCOut, bankDOut, fbOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // ratio maps taken from R2..R5
  int mapA[16]  = '{2,2,2,2,2,2,2,2,2,2,4,4,4,6,6,8};
  int mapB[16]  = '{2,2,4,2,6,4,4,6,2,8,4,6,6,6,8,8};
  int mapC[16]  = '{2,4,4,6,6,6,8,8,8,8,6,6,8,8,8,8};
  int mapFb[8]  = '{2,4,6,8,8,16,24,32};

  typedef struct {
    bit    a, b, c, d, f;
    bit    inReset;
    string dReq;
    string caseTag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  multibank_clkdiv dut_i (
    .clk      (clk),
    .masterRst(masterRst),
    .halfRate (halfRate),
    .bankSel  (bankSel),
    .fbSel    (fbSel),
    .syncSel  (syncSel),
    .bankAOut (bankAOut),
    .bankBOut (bankBOut),
    .bankCOut (bankCOut),
    .bankDOut (bankDOut),
    .fbOut    (fbOut)
  );

  function automatic int gcdOf(input int x, input int y);
    int p = x;
    int q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  // R6: high during the first half of every period, first step is a rise
  function automatic bit phaseHigh(input int ratio, input int k);
    if (k == 0) return 1'b0;
    return ((k - 1) % ratio) < (ratio / 2);
  endfunction

  // R8: pulse of one C period starting at each shared rise
  function automatic bit syncHigh(input int rA, input int rC, input int k);
    int l = rA / gcdOf(rA, rC) * rC;
    if (k == 0) return 1'b0;
    return ((k - 1) % l) < rC;
  endfunction

  task automatic checkBit(input bit act, input bit expv, input string req,
                          input string sig, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0b expected %0b at %0t",
               req, tag, sig, act, expv, $time);
    end
  endtask

  // driver: reset with new selections, then run and queue expectations
  task automatic runCase(input logic [3:0] bs, input logic [2:0] fs,
                         input bit hm, input bit sm, input int cycles,
                         input bit scramble, input string tag);
    int rA = mapA[bs];
    int rB = mapB[bs];
    int rC = mapC[bs];
    int rF = mapFb[fs];
    exp_t e;
    @(negedge clk);
    masterRst = 1'b1;
    bankSel = bs; fbSel = fs; halfRate = hm; syncSel = sm;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      e.a = 0; e.b = 0; e.c = 0; e.d = 0; e.f = 0;
      e.inReset = 1'b1; e.dReq = "R1"; e.caseTag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    masterRst = 1'b0;
    for (int c = 1; c <= cycles; c++) begin
      int k;
      @(posedge clk);
      k = hm ? (c + 1) / 2 : c;  // R7 step count
      e.a = phaseHigh(rA, k);
      e.b = phaseHigh(rB, k);
      e.c = phaseHigh(rC, k);
      e.f = phaseHigh(rF, k);
      e.d = sm ? e.c : syncHigh(rA, rC, k);
      e.inReset = 1'b0;
      e.dReq = sm ? "R9" : "R8";
      e.caseTag = tag;
      expQ.push_back(e);
      if (scramble && c == cycles / 2) begin
        @(negedge clk);  // R10: running changes must be ignored
        bankSel = ~bs; fbSel = ~fs; halfRate = !hm; syncSel = !sm;
      end
    end
  endtask

  // monitor: compares one expectation per source cycle, away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checkBit(bankAOut, cur.a, cur.inReset ? "R1" : "R2", "bankA", cur.caseTag);
      checkBit(bankBOut, cur.b, cur.inReset ? "R1" : "R3", "bankB", cur.caseTag);
      checkBit(bankCOut, cur.c, cur.inReset ? "R1" : "R4", "bankC", cur.caseTag);
      checkBit(fbOut,    cur.f, cur.inReset ? "R1" : "R5", "fb",    cur.caseTag);
      checkBit(bankDOut, cur.d, cur.dReq, "bankD", cur.caseTag);
    end
  end

  initial begin
    runCase(4'd0,  3'd0, 1'b0, 1'b0,  60, 1'b0, "R8 1:1 R6");
    runCase(4'd1,  3'd1, 1'b0, 1'b0,  60, 1'b0, "R8 2:1");
    runCase(4'd3,  3'd2, 1'b0, 1'b0,  80, 1'b0, "R8 3:1");
    runCase(4'd10, 3'd3, 1'b0, 1'b0,  80, 1'b0, "R8 3:2");
    runCase(4'd13, 3'd4, 1'b0, 1'b0, 100, 1'b0, "R8 4:3");
    runCase(4'd4,  3'd5, 1'b1, 1'b1, 120, 1'b0, "R7 R9");
    runCase(4'd15, 3'd7, 1'b1, 1'b0, 160, 1'b0, "R7 div32");
    runCase(4'd9,  3'd6, 1'b0, 1'b1, 120, 1'b1, "R10 copy");
    runCase(4'd14, 3'd1, 1'b0, 1'b0, 100, 1'b1, "R10 sync");
    runCase(4'd7,  3'd2, 1'b0, 1'b0,  60, 1'b0, "R1 after run");
    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule